// File: doc/BRIEF.md
# Branch Resolution and Commit Unit

This block sits at the end of the execute stage of an in-order core. Each cycle it can accept one instruction from the ALU. Every accepted instruction commits in that same cycle, in program order. For a conditional branch, the block evaluates the comparison on the two operands and checks the result against the taken or not-taken guess that fetch made. If the guess was wrong, the branch itself still commits, and the block raises a flush that cancels every younger instruction and redirects fetch to the correct address.

An interrupt or exception request raised alongside an accepted instruction behaves the same way. The instruction commits, and the younger ones are flushed to an externally supplied trap address. The block carries no condition codes. Arithmetic results never trigger a flush, and neither do late writeback errors from multi-cycle units, because those are handled elsewhere as asynchronous events.

The input side uses a valid/ready handshake. An instruction is accepted on a cycle where `in_valid` and `in_ready` are both high. `in_ready` drops for as long as a flush is outstanding, so the ALU must hold its instruction until `in_ready` returns. The flush request is held, together with its address and cause, until fetch acknowledges it.

Top module: `brcmt_unit`

## Requirements
- R1: After reset `flush_req` is 0, `flush_cause` is 0 and `in_ready` is 1.
- R2: `in_cond` selects the comparison using these encodings: 000 equal, 001 not equal, 100 signed less than, 101 signed greater or equal, 110 unsigned less than, 111 unsigned greater or equal. Each comparison is taken over the full `XLEN` bit operands.
- R3: A branch whose computed outcome matches `in_pred_taken` commits with no flush.
- R4: A branch whose outcome differs from `in_pred_taken` commits, and in the next cycle `flush_req` is 1 with `flush_cause` 0 (misprediction).
- R5: The misprediction redirect address depends on the actual outcome. If the branch is actually taken, the address is `in_pc + in_offset`. If it is actually not taken, the address is `in_pc + 2` when `in_rvc` is 1 and `in_pc + 4` otherwise.
- R6: When `trap_req` is high on an accepted instruction, that instruction commits, and in the next cycle `flush_req` is 1 with `flush_cause` 1 and `flush_pc` equal to `trap_pc`. This holds even when a misprediction occurs in the same cycle.
- R7: A non-branch instruction (`in_is_br` 0) commits with no flush whenever `trap_req` is 0, whatever its operands and prediction bit.
- R8: While `flush_req` is 1 and `flush_ack` is 0, the flush outputs stay unchanged, `in_ready` is 0 and no instruction commits.
- R9: A cycle with both `flush_req` and `flush_ack` high clears `flush_req`, and `in_ready` returns to 1 in the cycle after.
- R10: `cmt_valid` is high in exactly the cycles where `in_valid` and `in_ready` are both high, so at most one instruction commits per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction valid from the ALU |
| in_ready | output | 1 | Block can accept an instruction |
| in_is_br | input | 1 | Instruction is a conditional branch |
| in_cond | input | 3 | Branch comparison select |
| in_op_a | input | XLEN | First compare operand |
| in_op_b | input | XLEN | Second compare operand |
| in_pc | input | PCW | Address of the instruction |
| in_offset | input | PCW | Sign-extended branch offset |
| in_rvc | input | 1 | Instruction is 16 bits long |
| in_pred_taken | input | 1 | Direction predicted at fetch |
| trap_req | input | 1 | Interrupt or exception on the presented instruction |
| trap_pc | input | PCW | Redirect address for a trap flush |
| cmt_valid | output | 1 | Presented instruction commits this cycle |
| flush_req | output | 1 | Cancel younger instructions and redirect |
| flush_ack | input | 1 | Fetch has taken the flush |
| flush_pc | output | PCW | Redirect address |
| flush_cause | output | 1 | 0 misprediction, 1 trap |

## Verification
A corrupted flush register would show up at the ports no later than one cycle after the instruction that caused it. The symptoms would be a flush on a correctly predicted branch, a missing flush on a wrong guess, or a redirect address or cause that changes while the request is still pending. A pending state that never clears would leave `in_ready` stuck low, and the cycle after the acknowledge reveals it. Comparator faults show up as wrong flush decisions on boundary operands: the most negative value, zero and all ones, each paired against both a correct and an incorrect prediction.

// File: rtl/brcmt_pkg.sv
package brcmt_pkg;

  typedef enum logic [2:0] {
    CND_EQ  = 3'b000,
    CND_NE  = 3'b001,
    CND_LT  = 3'b100,
    CND_GE  = 3'b101,
    CND_LTU = 3'b110,
    CND_GEU = 3'b111
  } br_cond_e;

  typedef enum logic {
    CAUSE_MISPRED = 1'b0,
    CAUSE_TRAP    = 1'b1
  } flush_cause_e;

endpackage

// File: rtl/brcmt_cmp.sv
module brcmt_cmp #(
  parameter int XLEN = 32
) (
  input  logic [2:0]      cond_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            taken_o
);
  import brcmt_pkg::*;

  logic [XLEN:0] diff;
  logic          eq, ltu, lts;

  // One shared subtractor serves both compares; signs only differ in the signed case.
  assign diff = {1'b0, a_i} - {1'b0, b_i};
  assign eq   = (a_i == b_i);
  assign ltu  = diff[XLEN];
  assign lts  = (a_i[XLEN-1] ^ b_i[XLEN-1]) ? a_i[XLEN-1] : ltu;

  always_comb begin
    unique case (cond_i)
      CND_EQ:  taken_o = eq;
      CND_NE:  taken_o = ~eq;
      CND_LT:  taken_o = lts;
      CND_GE:  taken_o = ~lts;
      CND_LTU: taken_o = ltu;
      CND_GEU: taken_o = ~ltu;
      default: taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/brcmt_target.sv
module brcmt_target #(
  parameter int PCW     = 32,
  parameter bit HAS_RVC = 1'b1
) (
  input  logic [PCW-1:0] pc_i,
  input  logic [PCW-1:0] offset_i,
  input  logic           rvc_i,
  input  logic           taken_i,
  output logic [PCW-1:0] redirect_o
);
  localparam int STEP_W = 3;

  logic [STEP_W-1:0] step;
  logic [PCW-1:0]    seq_pc;
  logic [PCW-1:0]    jmp_pc;

  generate
    if (HAS_RVC) begin : g_rvc
      assign step = rvc_i ? STEP_W'(2) : STEP_W'(4);
    end else begin : g_norvc
      logic unused_rvc;
      assign unused_rvc = rvc_i;
      assign step = STEP_W'(4);
    end
  endgenerate

  assign seq_pc     = pc_i + PCW'(step);
  assign jmp_pc     = pc_i + offset_i;
  assign redirect_o = taken_i ? jmp_pc : seq_pc;
endmodule

// File: rtl/brcmt_flush_ctl.sv
module brcmt_flush_ctl #(
  parameter int PCW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           set_i,
  input  logic           cause_i,
  input  logic [PCW-1:0] pc_i,
  input  logic           ack_i,
  output logic           req_o,
  output logic           cause_o,
  output logic [PCW-1:0] pc_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_o   <= 1'b0;
      cause_o <= 1'b0;
      pc_o    <= '0;
    end else if (set_i) begin
      req_o   <= 1'b1;
      cause_o <= cause_i;
      pc_o    <= pc_i;
    end else if (req_o && ack_i) begin
      req_o   <= 1'b0;
    end
  end
endmodule

// File: rtl/brcmt_unit.sv
module brcmt_unit #(
  parameter int XLEN    = 32,
  parameter int PCW     = 32,
  parameter bit HAS_RVC = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_is_br,
  input  logic [2:0]      in_cond,
  input  logic [XLEN-1:0] in_op_a,
  input  logic [XLEN-1:0] in_op_b,
  input  logic [PCW-1:0]  in_pc,
  input  logic [PCW-1:0]  in_offset,
  input  logic            in_rvc,
  input  logic            in_pred_taken,
  input  logic            trap_req,
  input  logic [PCW-1:0]  trap_pc,
  output logic            cmt_valid,
  output logic            flush_req,
  input  logic            flush_ack,
  output logic [PCW-1:0]  flush_pc,
  output logic            flush_cause
);
  import brcmt_pkg::*;

  logic           taken, mispred, fire, flush_set;
  logic           nxt_cause;
  logic [PCW-1:0] redirect, nxt_pc;

  brcmt_cmp #(.XLEN(XLEN)) u_cmp (
    .cond_i  (in_cond),
    .a_i     (in_op_a),
    .b_i     (in_op_b),
    .taken_o (taken)
  );

  brcmt_target #(.PCW(PCW), .HAS_RVC(HAS_RVC)) u_tgt (
    .pc_i       (in_pc),
    .offset_i   (in_offset),
    .rvc_i      (in_rvc),
    .taken_i    (taken),
    .redirect_o (redirect)
  );

  assign in_ready  = ~flush_req;
  assign fire      = in_valid & in_ready;
  assign cmt_valid = fire;
  assign mispred   = in_is_br & (taken ^ in_pred_taken);
  assign flush_set = fire & (trap_req | mispred);
  assign nxt_cause = trap_req ? CAUSE_TRAP : CAUSE_MISPRED;
  assign nxt_pc    = trap_req ? trap_pc : redirect;

  brcmt_flush_ctl #(.PCW(PCW)) u_fl (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (flush_set),
    .cause_i (nxt_cause),
    .pc_i    (nxt_pc),
    .ack_i   (flush_ack),
    .req_o   (flush_req),
    .cause_o (flush_cause),
    .pc_o    (flush_pc)
  );
endmodule

// File: rtl/brcmt_chk.sv
module brcmt_chk #(
  parameter int PCW = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic           in_is_br,
  input logic           trap_req,
  input logic           cmt_valid,
  input logic           flush_req,
  input logic           flush_ack,
  input logic [PCW-1:0] flush_pc,
  input logic           flush_cause
);
  // R8
  hold_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req && !flush_ack |=> flush_req && $stable(flush_pc) && $stable(flush_cause));
  // R8
  no_commit_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> !cmt_valid);
  // R9
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req && flush_ack |=> !flush_req && in_ready);
  // R6
  trap_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid && trap_req |=> flush_req && flush_cause);
  // R7
  nonbr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid && !in_is_br && !trap_req |=> !flush_req);
  // R10
  cmt_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |-> in_valid && in_ready);
endmodule

bind brcmt_unit brcmt_chk #(.PCW(PCW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_is_br    (in_is_br),
  .trap_req    (trap_req),
  .cmt_valid   (cmt_valid),
  .flush_req   (flush_req),
  .flush_ack   (flush_ack),
  .flush_pc    (flush_pc),
  .flush_cause (flush_cause)
);

// File: tb/sim_brcmt_unit.sv
`timescale 1ns/1ps
module sim_brcmt_unit;
  localparam int XLEN = 32;
  localparam int PCW  = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0, in_ready, in_is_br = 1'b0;
  logic [2:0]      in_cond = 3'b000;
  logic [XLEN-1:0] in_op_a = '0, in_op_b = '0;
  logic [PCW-1:0]  in_pc = '0, in_offset = '0, trap_pc = '0;
  logic            in_rvc = 1'b0, in_pred_taken = 1'b0, trap_req = 1'b0;
  logic            cmt_valid, flush_req, flush_ack = 1'b0, flush_cause;
  logic [PCW-1:0]  flush_pc;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  brcmt_unit #(.XLEN(XLEN), .PCW(PCW)) u0 (
    .clk, .rst_n, .in_valid, .in_ready, .in_is_br, .in_cond, .in_op_a, .in_op_b,
    .in_pc, .in_offset, .in_rvc, .in_pred_taken, .trap_req, .trap_pc,
    .cmt_valid, .flush_req, .flush_ack, .flush_pc, .flush_cause
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit ref_taken(input logic [2:0] c, input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    case (c)
      3'b000: return a == b;
      3'b001: return a != b;
      3'b100: return $signed(a) < $signed(b);
      3'b101: return $signed(a) >= $signed(b);
      3'b110: return a < b;
      3'b111: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [2:0] cond_of(input int k);
    logic [2:0] t[6] = '{3'b000, 3'b001, 3'b100, 3'b101, 3'b110, 3'b111};
    return t[k];
  endfunction

  function automatic logic [XLEN-1:0] pick_op(input int k);
    case (k)
      0: return {1'b1, {(XLEN-1){1'b0}}};
      1: return '0;
      2: return '1;
      3: return {1'b0, {(XLEN-1){1'b1}}};
      4: return XLEN'(1);
      default: return XLEN'($urandom);
    endcase
  endfunction

  task automatic run_op(input bit br, input logic [2:0] c, input logic [XLEN-1:0] a,
                        input logic [XLEN-1:0] b, input logic [PCW-1:0] pc,
                        input logic [PCW-1:0] off, input bit rvc, input bit pred,
                        input bit trp, input logic [PCW-1:0] tpc, input int hold);
    bit tk, exp_fl;
    logic [PCW-1:0] exp_pc;
    tk     = ref_taken(c, a, b);
    exp_fl = trp | (br & (tk != pred));
    exp_pc = trp ? tpc : (tk ? pc + off : pc + (rvc ? 2 : 4));
    @(negedge clk);
    in_valid = 1'b1; in_is_br = br; in_cond = c; in_op_a = a; in_op_b = b;
    in_pc = pc; in_offset = off; in_rvc = rvc; in_pred_taken = pred;
    trap_req = trp; trap_pc = tpc;
    #1;
    chk("R10 commit on handshake", cmt_valid, 1);
    @(negedge clk);
    in_valid = 1'b0; trap_req = 1'b0;
    if (trp) chk("R6 trap flush", flush_req, 1);
    else if (!br) chk("R7 non-branch no flush", flush_req, 0);
    else if (exp_fl) chk("R4 mispredict flush", flush_req, 1);
    else chk("R3 correct prediction no flush", flush_req, 0);
    if (br && !trp) chk("R2 condition evaluation", flush_req, exp_fl);
    if (exp_fl) begin
      chk(trp ? "R6 trap cause" : "R4 mispredict cause", flush_cause, trp);
      chk(trp ? "R6 trap pc" : "R5 redirect pc", flush_pc, exp_pc);
      for (int i = 0; i < hold; i++) begin
        in_valid = 1'b1;
        #1;
        chk("R8 ready low while pending", in_ready, 0);
        chk("R8 no commit while pending", cmt_valid, 0);
        @(negedge clk);
        chk("R8 request held", flush_req, 1);
        chk("R8 pc held", flush_pc, exp_pc);
      end
      in_valid = 1'b0;
      flush_ack = 1'b1;
      @(negedge clk);
      flush_ack = 1'b0;
      chk("R9 ack clears request", flush_req, 0);
      chk("R9 ready restored", in_ready, 1);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 reset flush_req", flush_req, 0);
    chk("R1 reset cause", flush_cause, 0);
    chk("R1 reset in_ready", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", in_ready, 1);

    // Directed: every condition against boundary operand pairs, both predictions
    for (int c = 0; c < 6; c++)
      for (int ia = 0; ia < 3; ia++)
        for (int ib = 0; ib < 3; ib++)
          for (int p = 0; p < 2; p++)
            run_op(1'b1, cond_of(c), pick_op(ia), pick_op(ib), 32'h0000_1000,
                   32'hFFFF_FFF0, ia[0], p[0], 1'b0, '0, 0);

    // R5 compressed versus full-length fall-through, forward/backward targets
    run_op(1'b1, 3'b000, 32'd1, 32'd2, 32'h0000_2000, 32'h0000_0100, 1'b1, 1'b1, 1'b0, '0, 1);
    run_op(1'b1, 3'b000, 32'd1, 32'd2, 32'h0000_2000, 32'h0000_0100, 1'b0, 1'b1, 1'b0, '0, 1);
    run_op(1'b1, 3'b001, 32'd1, 32'd2, 32'h0000_2000, 32'hFFFF_FF00, 1'b0, 1'b0, 1'b0, '0, 2);
    // R6 trap outranks a simultaneous misprediction
    run_op(1'b1, 3'b000, 32'd5, 32'd5, 32'h0000_3000, 32'h40, 1'b0, 1'b0, 1'b1, 32'h0000_0080, 2);
    // R7 non-branch with prediction bit and unequal operands set
    run_op(1'b0, 3'b000, 32'd7, 32'd9, 32'h0000_4000, 32'h40, 1'b0, 1'b1, 1'b0, '0, 0);
    run_op(1'b0, 3'b001, 32'd7, 32'd7, 32'h0000_4004, 32'h40, 1'b1, 1'b0, 1'b1, 32'h0000_0100, 1);

    // Constrained random mix
    for (int n = 0; n < 400; n++) begin
      run_op(($urandom % 4) != 0, cond_of($urandom % 6), pick_op($urandom % 7),
             pick_op($urandom % 7), {$urandom, 1'b0} & 32'hFFFF_FFFE,
             {{20{$urandom % 2 == 1}}, 12'($urandom)} & 32'hFFFF_FFFE,
             $urandom % 2, $urandom % 2, ($urandom % 10) == 0,
             $urandom & 32'hFFFF_FFFC, $urandom % 3);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
      end
    join_any
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule